// File: doc/BRIEF.md
# NAND Bus Cycle Strobe Timer

This block turns a single cycle request into a correctly timed NAND flash bus cycle. A request names the cycle kind, the direction and a write byte. The cycle kind is command, address or data, and the direction is read or write. The block then drives the chip enable, command latch, address latch, write strobe, read strobe and data-bus enable through three phases: setup, strobe pulse and hold. When the read strobe is released it captures the byte on the bus into a 32-bit read word. A one-clock done pulse closes every cycle.

All phase lengths come from one 32-bit timing word. Its lower half times read cycles and its upper half times write cycles. Each half holds a setup count, a hold count, a strobe width and a ready-sample wait. After a command cycle the block ignores the ready/busy pin for a programmable number of clock pairs. This covers the time the flash needs to pull its busy line low. No new cycle starts before that wait ends or while the ready pin is low.

Top module: `nand_strobe_timer`

## Requirements
- R1: While reset is asserted and after it is released with no request, the outputs are idle: we_n=1, re_n=1, ce_n=1, cle=0, ale=0, bus_oe=0, bus_dout=0, done=0, rdata=0.
- R2: A data read cycle (req_kind=2 or 3 with req_write=0) takes its timing from the lower half of timing_cfg: bits [3:0] setup, [7:4] hold, [11:8] strobe width.
- R3: Command, address and data write cycles take their timing from the upper half: bits [19:16] setup, [23:20] hold, [27:24] strobe width.
- R4: A cycle accepted at a clock edge runs in order: setup for n+1 clocks, then strobe pulse for n+1 clocks, then hold for n+1 clocks, then one done clock, then idle. Each n is the 4-bit field value, so each phase lasts 1 to 16 clocks.
- R5: Only the pulse phase drives a strobe low. Read cycles drive re_n and write-type cycles drive we_n, and the two strobes are never low together.
- R6: During setup, pulse and hold, ce_n is 0. cle is 1 for a command cycle (req_kind=0) and ale is 1 for an address cycle (req_kind=1). Kinds 2 and 3 are data cycles with both latches at 0. In idle and done, ce_n=1 and cle=ale=0.
- R7: For write-type cycles, bus_oe is 1 and bus_dout carries the request byte through setup, pulse and hold. For reads, and outside a cycle, bus_oe=0 and bus_dout=0.
- R8: A read cycle loads rdata with bus_din, zero-extended to 32 bits, at the edge where re_n returns high. rdata holds its value at all other edges.
- R9: done is high for exactly the one clock after the hold phase, with every strobe and enable idle.
- R10: After a command cycle, ready_stat is 0 for 2*n clocks starting with the done clock, then follows ready_pin. n is bits [31:28] when the command had req_write=1 and bits [15:12] when it had req_write=0. Outside that wait, ready_stat equals ready_pin.
- R11: A request is taken only at an edge where the block is idle (not in a cycle or its done clock), the post-command wait has ended and ready_pin is 1. Any other request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_cfg | input | 32 | Read timing (low half) and write timing (high half) |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 2 | 0 command, 1 address, 2/3 data |
| req_write | input | 1 | Data direction; for commands selects which wait field applies |
| req_wdata | input | 8 | Byte driven in a write-type cycle |
| ready_pin | input | 1 | Flash ready/busy line, 1 = ready |
| bus_din | input | 8 | Flash data bus input |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ce_n | output | 1 | Chip enable, active low |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | 8 | Data bus output |
| rdata | output | 32 | Captured read byte, zero-extended |
| done | output | 1 | One-clock end-of-cycle pulse |
| ready_stat | output | 1 | Ready status after the post-command wait |

## Verification
The bench applies all-zero fields, where every phase is one clock, and all-ones fields, where every phase is sixteen clocks. A counter that is off by one would stretch or cut a phase by a clock, and the per-clock comparison of ce_n and the strobes would catch it. The read bus changes every clock, so capturing one edge early or late shows up as a different rdata byte. The bench selects the command wait from both halves of the timing word and holds requests during a cycle, during the wait and with ready low. A design that took the wrong wait field, or that accepted a request early, would start ce_n too soon.

// File: rtl/nst_pkg.sv
`timescale 1ns/1ps
package nst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_PULSE = 3'd2,
        ST_HOLD  = 3'd3,
        ST_DONE  = 3'd4
    } phase_e;

    localparam logic [1:0] KIND_CMD  = 2'd0;
    localparam logic [1:0] KIND_ADDR = 2'd1;

    localparam int TF_W = 4;

endpackage

// File: rtl/nst_timing_sel.sv
`timescale 1ns/1ps
module nst_timing_sel #(
    parameter int FIELD_W = 4
) (
    input  logic [8*FIELD_W-1:0] cfg,
    input  logic                 sel_read,
    input  logic                 wait_read,
    output logic [FIELD_W-1:0]   setup_n,
    output logic [FIELD_W-1:0]   width_n,
    output logic [FIELD_W-1:0]   hold_n,
    output logic [FIELD_W-1:0]   wait_n
);
    localparam int GRP_W = 4 * FIELD_W;

    // group 0 times reads, group 1 times writes
    logic [FIELD_W-1:0] f_setup [2];
    logic [FIELD_W-1:0] f_hold  [2];
    logic [FIELD_W-1:0] f_width [2];
    logic [FIELD_W-1:0] f_wait  [2];

    for (genvar g = 0; g < 2; g++) begin : g_grp
        assign f_setup[g] = cfg[g*GRP_W + 0*FIELD_W +: FIELD_W];
        assign f_hold[g]  = cfg[g*GRP_W + 1*FIELD_W +: FIELD_W];
        assign f_width[g] = cfg[g*GRP_W + 2*FIELD_W +: FIELD_W];
        assign f_wait[g]  = cfg[g*GRP_W + 3*FIELD_W +: FIELD_W];
    end

    assign setup_n = sel_read  ? f_setup[0] : f_setup[1];
    assign hold_n  = sel_read  ? f_hold[0]  : f_hold[1];
    assign width_n = sel_read  ? f_width[0] : f_width[1];
    assign wait_n  = wait_read ? f_wait[0]  : f_wait[1];

endmodule

// File: rtl/nst_phase_cnt.sv
`timescale 1ns/1ps
module nst_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/nst_rdy_wait.sv
`timescale 1ns/1ps
module nst_rdy_wait #(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_W-1:0] pairs,
    output logic               idle
);
    localparam int CW = FIELD_W + 1;

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (start) begin
            left_d = {pairs, 1'b0};
        end else if (left_q != '0) begin
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign idle = (left_q == '0);

endmodule

// File: rtl/nand_strobe_timer.sv
`timescale 1ns/1ps
module nand_strobe_timer
    import nst_pkg::*;
#(
    parameter int FIELD_W = TF_W,
    parameter int DATA_W  = 8,
    parameter int WORD_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [8*FIELD_W-1:0] timing_cfg,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 ready_pin,
    input  logic [DATA_W-1:0]    bus_din,
    output logic                 we_n,
    output logic                 re_n,
    output logic                 cle,
    output logic                 ale,
    output logic                 ce_n,
    output logic                 bus_oe,
    output logic [DATA_W-1:0]    bus_dout,
    output logic [WORD_W-1:0]    rdata,
    output logic                 done,
    output logic                 ready_stat
);
    localparam int PAD_W = WORD_W - DATA_W;

    typedef struct packed {
        phase_e              phase;
        logic [1:0]          kind;
        logic                is_rd;
        logic                wait_rd;
        logic [DATA_W-1:0]   wdata;
        logic [WORD_W-1:0]   rdata;
        logic                we_n;
        logic                re_n;
        logic                cle;
        logic                ale;
        logic                ce_n;
        logic                oe;
        logic [DATA_W-1:0]   dout;
        logic                done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        phase:   ST_IDLE,
        kind:    2'd0,
        is_rd:   1'b0,
        wait_rd: 1'b0,
        wdata:   '0,
        rdata:   '0,
        we_n:    1'b1,
        re_n:    1'b1,
        cle:     1'b0,
        ale:     1'b0,
        ce_n:    1'b1,
        oe:      1'b0,
        dout:    '0,
        done:    1'b0
    };

    ctl_t d, q;

    logic               fire;
    logic               in_is_rd;
    logic               sel_read;
    logic [FIELD_W-1:0] setup_n, width_n, hold_n, wait_n;
    logic               cnt_load;
    logic [FIELD_W-1:0] cnt_val;
    logic               cnt_zero;
    logic               wait_start;
    logic               wait_idle;
    logic               active;

    // kinds 2 and 3 are data; only a data cycle can be a read
    assign in_is_rd = req_kind[1] & ~req_write;
    assign sel_read = (q.phase == ST_IDLE) ? in_is_rd : q.is_rd;
    assign fire     = req_valid & (q.phase == ST_IDLE) & wait_idle & ready_pin;

    nst_timing_sel #(.FIELD_W(FIELD_W)) u_sel (
        .cfg       (timing_cfg),
        .sel_read  (sel_read),
        .wait_read (q.wait_rd),
        .setup_n   (setup_n),
        .width_n   (width_n),
        .hold_n    (hold_n),
        .wait_n    (wait_n)
    );

    nst_phase_cnt #(.W(FIELD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    nst_rdy_wait #(.FIELD_W(FIELD_W)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wait_start),
        .pairs (wait_n),
        .idle  (wait_idle)
    );

    always_comb begin
        d          = q;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        wait_start = 1'b0;

        unique case (q.phase)
            ST_IDLE: begin
                if (fire) begin
                    d.phase   = ST_SETUP;
                    d.kind    = req_kind;
                    d.is_rd   = in_is_rd;
                    d.wait_rd = ~req_write;
                    d.wdata   = req_wdata;
                    cnt_load  = 1'b1;
                    cnt_val   = setup_n;
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    d.phase  = ST_PULSE;
                    cnt_load = 1'b1;
                    cnt_val  = width_n;
                end
            end
            ST_PULSE: begin
                if (cnt_zero) begin
                    d.phase  = ST_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = hold_n;
                    if (q.is_rd) begin
                        d.rdata = {{PAD_W{1'b0}}, bus_din};
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    d.phase    = ST_DONE;
                    wait_start = (q.kind == KIND_CMD);
                end
            end
            ST_DONE: begin
                d.phase = ST_IDLE;
            end
            default: begin
                d.phase = ST_IDLE;
            end
        endcase

        // pin levels follow the phase being entered, so they leave a register
        active = (d.phase == ST_SETUP) || (d.phase == ST_PULSE) || (d.phase == ST_HOLD);
        d.ce_n = ~active;
        d.cle  = active & (d.kind == KIND_CMD);
        d.ale  = active & (d.kind == KIND_ADDR);
        d.oe   = active & ~d.is_rd;
        d.dout = d.oe ? d.wdata : '0;
        d.we_n = ~((d.phase == ST_PULSE) & ~d.is_rd);
        d.re_n = ~((d.phase == ST_PULSE) &  d.is_rd);
        d.done = (d.phase == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign we_n       = q.we_n;
    assign re_n       = q.re_n;
    assign cle        = q.cle;
    assign ale        = q.ale;
    assign ce_n       = q.ce_n;
    assign bus_oe     = q.oe;
    assign bus_dout   = q.dout;
    assign rdata      = q.rdata;
    assign done       = q.done;
    assign ready_stat = wait_idle & ready_pin;

endmodule

// File: rtl/nst_checker.sv
`timescale 1ns/1ps
module nst_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we_n,
    input logic              re_n,
    input logic              cle,
    input logic              ale,
    input logic              ce_n,
    input logic              bus_oe,
    input logic              done,
    input logic [WORD_W-1:0] rdata
);
    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    assert_strobe_needs_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);

    assert_latch_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !bus_oe);

    assert_rdata_only_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(re_n) |-> $stable(rdata));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ce_n && we_n && re_n && !bus_oe));

endmodule

bind nand_strobe_timer nst_checker #(.WORD_W(WORD_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_n   (we_n),
    .re_n   (re_n),
    .cle    (cle),
    .ale    (ale),
    .ce_n   (ce_n),
    .bus_oe (bus_oe),
    .done   (done),
    .rdata  (rdata)
);

// File: tb/nand_strobe_timer_tb.sv
`timescale 1ns/1ps
module nand_strobe_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_cfg = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        ready_pin = 1'b1;
    logic [7:0]  bus_din = 8'h11;
    logic        we_n, re_n, cle, ale, ce_n, bus_oe, done, ready_stat;
    logic [7:0]  bus_dout;
    logic [31:0] rdata;

    always #2.5 clk = ~clk;

    nand_strobe_timer u_dut (
        .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg),
        .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write),
        .req_wdata(req_wdata), .ready_pin(ready_pin), .bus_din(bus_din),
        .we_n(we_n), .re_n(re_n), .cle(cle), .ale(ale), .ce_n(ce_n),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .rdata(rdata), .done(done),
        .ready_stat(ready_stat)
    );

    typedef struct packed {
        logic       we_n, re_n, cle, ale, ce_n, oe, done, cap, sw;
        logic [3:0] wn;
        logic [7:0] dout;
    } exp_t;

    exp_t        sched[$];
    exp_t        cur;
    logic        cur_busy = 1'b0;
    int          wait_rem = 0;
    logic [31:0] rdata_exp = '0;
    logic [7:0]  din_prev = '0;
    int          vectors = 0;
    int          miscompares = 0;
    string       tag = "R1 reset";

    function automatic exp_t idle_e();
        exp_t e = '0;
        e.we_n = 1'b1; e.re_n = 1'b1; e.ce_n = 1'b1;
        return e;
    endfunction

    // expected per-clock pin levels for one accepted cycle
    task automatic push_cycle(input logic [1:0] k, input logic wr, input logic [7:0] dat);
        logic        rd  = k[1] && !wr;
        logic [15:0] grp = rd ? timing_cfg[15:0] : timing_cfg[31:16];
        int          s = int'(grp[3:0]);
        int          h = int'(grp[7:4]);
        int          w = int'(grp[11:8]);
        exp_t        base = '0;
        exp_t        e;
        base.ce_n = 1'b0;
        base.cle  = (k == 2'd0);
        base.ale  = (k == 2'd1);
        base.oe   = !rd;
        base.dout = rd ? 8'h00 : dat;
        base.we_n = 1'b1;
        base.re_n = 1'b1;
        for (int i = 0; i <= s; i++) sched.push_back(base);
        for (int i = 0; i <= w; i++) begin
            e = base; e.we_n = rd; e.re_n = !rd;
            sched.push_back(e);
        end
        for (int i = 0; i <= h; i++) begin
            e = base; e.cap = rd && (i == 0);
            sched.push_back(e);
        end
        e = idle_e();
        e.done = 1'b1;
        e.sw   = (k == 2'd0);
        e.wn   = wr ? timing_cfg[31:28] : timing_cfg[15:12];
        sched.push_back(e);
    endtask

    task automatic chk(input string sig, input string req, input logic [31:0] act, input logic [31:0] exv);
        if (act !== exv) begin
            miscompares++;
            $display("FAIL %s %s [%s]: actual %h expected %h", req, sig, tag, act, exv);
        end
    endtask

    task automatic step();
        if (rst_n && req_valid && !cur_busy && wait_rem == 0 && ready_pin)
            push_cycle(req_kind, req_write, req_wdata);
        din_prev = bus_din;
        @(negedge clk);
        if (wait_rem > 0) wait_rem--;
        if (sched.size() > 0) begin
            cur = sched.pop_front();
            cur_busy = 1'b1;
        end else begin
            cur = idle_e();
            cur_busy = 1'b0;
        end
        if (cur.cap) rdata_exp = {24'h0, din_prev};
        if (cur.sw)  wait_rem = 2 * int'(cur.wn);
        vectors++;
        chk("we_n",       "R5",  {31'h0, we_n},     {31'h0, cur.we_n});
        chk("re_n",       "R5",  {31'h0, re_n},     {31'h0, cur.re_n});
        chk("cle",        "R6",  {31'h0, cle},      {31'h0, cur.cle});
        chk("ale",        "R6",  {31'h0, ale},      {31'h0, cur.ale});
        chk("ce_n",       "R4",  {31'h0, ce_n},     {31'h0, cur.ce_n});
        chk("bus_oe",     "R7",  {31'h0, bus_oe},   {31'h0, cur.oe});
        chk("bus_dout",   "R7",  {24'h0, bus_dout}, {24'h0, cur.dout});
        chk("done",       "R9",  {31'h0, done},     {31'h0, cur.done});
        chk("rdata",      "R8",  rdata,             rdata_exp);
        chk("ready_stat", "R10", {31'h0, ready_stat},
            {31'h0, (wait_rem == 0) && ready_pin});
        bus_din = bus_din + 8'h3B;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            if (!cur_busy && sched.size() == 0 && wait_rem == 0) break;
            step();
        end
        step();
    endtask

    task automatic issue(input logic [1:0] k, input logic wr, input logic [7:0] dat);
        req_valid = 1'b1; req_kind = k; req_write = wr; req_wdata = dat;
        step();
        req_valid = 1'b0;
        drain();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R1: idle outputs under reset and just after release
        tag = "R1 reset";
        run(3);
        rst_n = 1'b1;
        run(2);

        // write: wait 3, width 2, hold 1, setup 0; read: wait 2, width 4, hold 2, setup 1
        timing_cfg = 32'h3210_2421;
        tag = "R3 R4 R10 command, write wait field";
        issue(2'd0, 1'b1, 8'hA5);

        tag = "R11 request held across cycle and command wait";
        req_valid = 1'b1; req_kind = 2'd1; req_write = 1'b1; req_wdata = 8'h3C;
        run(3);
        req_valid = 1'b0;
        run(6);
        drain();

        tag = "R6 address cycle";
        issue(2'd1, 1'b1, 8'h3C);
        tag = "R3 R7 data write";
        issue(2'd2, 1'b1, 8'h5A);
        tag = "R2 R8 data read";
        issue(2'd2, 1'b0, 8'hFF);
        tag = "R10 command, read wait field";
        issue(2'd0, 1'b0, 8'h70);

        tag = "R11 ready pin low blocks start";
        ready_pin = 1'b0;
        req_valid = 1'b1; req_kind = 2'd2; req_write = 1'b0;
        run(8);
        ready_pin = 1'b1;
        step();
        req_valid = 1'b0;
        drain();

        tag = "R11 back-to-back reads, busy requests ignored";
        req_valid = 1'b1; req_kind = 2'd2; req_write = 1'b0;
        run(30);
        req_valid = 1'b0;
        drain();

        tag = "R4 all fields at maximum";
        timing_cfg = 32'hFFFF_FFFF;
        issue(2'd2, 1'b0, 8'h00);
        issue(2'd2, 1'b1, 8'hC3);
        issue(2'd0, 1'b1, 8'h90);

        tag = "R4 R10 all fields zero";
        timing_cfg = 32'h0000_0000;
        issue(2'd0, 1'b1, 8'hFF);
        issue(2'd2, 1'b0, 8'h00);
        issue(2'd1, 1'b1, 8'h01);

        tag = "R6 kind 3 treated as data";
        timing_cfg = 32'h1123_5132;
        issue(2'd3, 1'b0, 8'h00);
        issue(2'd3, 1'b1, 8'h7E);
        issue(2'd0, 1'b0, 8'hEE);

        finish_run();
    end

endmodule